// File: doc/BRIEF.md
# Octal DDR PSRAM Transaction Engine

This block runs one transaction at a time on an octal double-data-rate pseudo-static RAM bus. A requester hands over a transaction kind, a 32-bit address, write data and a byte count on a valid/ready port. The engine then drives chip select, the bus clock and an 8-bit data bus through four shift phases: a doubled-byte opcode, a four-byte address, an optional dummy phase and the data phase. It returns read bytes together with a one-cycle completion strobe.

The bus clock runs at half the system clock. Each system cycle inside a shift phase is one bus clock edge, and each edge carries one byte. Chip-select setup, hold and minimum-high times, and both dummy lengths, are parameters. The defaults are 3, 3 and 2 bus clocks, 18 read dummy edges and 8 array-write dummy edges. The block can run array reads and writes of up to `MAX_BYTES` bytes, and mode-register reads and writes.

Top module: `opi_psram_engine`

## Requirements
- R1: After reset the engine has chip select high, bus clock low, output enable low, request ready high and the done strobe low.
- R2: Kind encoding: 0 = array read, 1 = array write, 2 = register read, 3 = register write. The opcode byte is 0x00, 0x80, 0x40 or 0xC0 respectively, and it is sent on both edges of the first bus clock.
- R3: The 32-bit address follows on the next four edges, most significant byte first.
- R4: Both read kinds insert `RD_DUMMY` (18) edges between address and data. Array writes insert `WR_DUMMY` (8) edges. Register writes go straight from address to data.
- R5: Chip select falls 2×`CS_SETUP` system cycles (3 bus clocks) before the first command edge. It stays low for 2×`CS_HOLD` system cycles after the last data edge, with the bus clock low.
- R6: Between two transactions, chip select stays high for at least 2×`CS_HIGH` system cycles (2 bus clocks).
- R7: The bus clock is low whenever chip select is high. During shift phases it toggles every system cycle, so each phase covers whole bus clocks.
- R8: Output enable is high for the command and address edges. For writes it stays high through the dummy and data edges. For reads it is low from the first dummy edge until chip select rises.
- R9: An array write sends the effective byte count of bytes from `req_wdata_i`, byte 0 (bits 7:0) first. An odd count is padded with one zero byte to fill a whole bus clock.
- R10: On an array read, the byte on data edge k lands in `rd_data_o[8k+7:8k]`. A padding edge is discarded and bytes beyond the count read as zero. The effective count is 1 for a count of 0, and `MAX_BYTES` for a count above `MAX_BYTES`.
- R11: A register read returns at most 2 bytes, and a 1-byte read still runs one full bus clock. A register write always sends two bytes, `req_wdata_i[7:0]` then `[15:8]`, whatever the count.
- R12: Request ready is low from acceptance until the chip-select high time has expired. A request held valid meanwhile is accepted afterwards. `done_o` pulses for one cycle as chip select rises, and `rd_data_o` holds until the next acceptance.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine can accept a request |
| req_kind_i | input | 2 | Transaction kind (R2 encoding) |
| req_addr_i | input | 32 | Transaction address |
| req_wdata_i | input | 8×MAX_BYTES | Write bytes, byte 0 lowest |
| req_len_i | input | $clog2(MAX_BYTES+1) | Byte count |
| done_o | output | 1 | One-cycle completion strobe |
| rd_data_o | output | 8×MAX_BYTES | Read bytes, byte 0 lowest |
| cs_n_o | output | 1 | Bus chip select, active low |
| sck_o | output | 1 | Bus clock |
| dq_o | output | 8 | Data bus output |
| dq_oe_o | output | 1 | Data bus output enable |
| dq_i | input | 8 | Data bus input |

## Verification
The assertions assume that a requester keeps `req_valid_i` high once it has raised it until ready accepts it. They also assume that the chip-select parameters are at least one bus clock. The bench drives requests only from its issue task, which holds valid until acceptance, including the case where a second request waits behind a busy transaction. The device model drives `dq_i` only during read data edges, so the capture-versus-enable check sees the bus the way a real part would turn it.

// File: rtl/opi_pkg.sv
package opi_pkg;
  typedef enum logic [1:0] {
    KIND_ARR_RD = 2'd0,
    KIND_ARR_WR = 2'd1,
    KIND_REG_RD = 2'd2,
    KIND_REG_WR = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_HOLD, ST_GAP
  } state_e;

  function automatic logic [7:0] opcode_byte(kind_e k);
    case (k)
      KIND_ARR_RD: return 8'h00;
      KIND_ARR_WR: return 8'h80;
      KIND_REG_RD: return 8'h40;
      default:     return 8'hC0;
    endcase
  endfunction

  function automatic logic is_read(kind_e k);
    return !k[0];
  endfunction

  function automatic logic is_shift(state_e s);
    return (s == ST_CMD) || (s == ST_ADDR) || (s == ST_DUMMY) || (s == ST_DATA);
  endfunction
endpackage

// File: rtl/opi_phase_seq.sv
module opi_phase_seq
  import opi_pkg::*;
#(
  parameter int CS_SETUP = 3,
  parameter int CS_HOLD  = 3,
  parameter int CS_HIGH  = 2,
  parameter int RD_DUMMY = 18,
  parameter int WR_DUMMY = 8,
  parameter int CNT_W    = 5,
  parameter int EDGE_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  kind_e             kind_i,
  input  logic [EDGE_W-1:0] data_edges_i,
  output state_e            state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              done_o
);
  localparam int GAP_CYC = 2 * CS_HIGH;

  state_e           st_q;
  logic [CNT_W-1:0] cnt_q, len, dummy_len, hi_run_q;
  logic             at_end, done_q;

  always_comb begin
    if (is_read(kind_i))            dummy_len = CNT_W'(RD_DUMMY);
    else if (kind_i == KIND_REG_WR) dummy_len = '0;
    else                            dummy_len = CNT_W'(WR_DUMMY);
    case (st_q)
      ST_SETUP: len = CNT_W'(2 * CS_SETUP);
      ST_CMD:   len = CNT_W'(2);
      ST_ADDR:  len = CNT_W'(4);
      ST_DUMMY: len = dummy_len;
      ST_DATA:  len = CNT_W'(data_edges_i);
      ST_HOLD:  len = CNT_W'(2 * CS_HOLD);
      ST_GAP:   len = CNT_W'(GAP_CYC);
      default:  len = CNT_W'(1);
    endcase
  end

  assign at_end = (cnt_q == len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_HOLD) && at_end;
      if (st_q == ST_IDLE) begin
        cnt_q <= '0;
        if (start_i) st_q <= ST_SETUP;
      end else if (at_end) begin
        cnt_q <= '0;
        case (st_q)
          ST_SETUP: st_q <= ST_CMD;
          ST_CMD:   st_q <= ST_ADDR;
          ST_ADDR:  st_q <= (dummy_len == '0) ? ST_DATA : ST_DUMMY;
          ST_DUMMY: st_q <= ST_DATA;
          ST_DATA:  st_q <= ST_HOLD;
          ST_HOLD:  st_q <= ST_GAP;
          default:  st_q <= ST_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
  assign cs_n_o  = (st_q == ST_IDLE) || (st_q == ST_GAP);
  // even count = rising half of the bus clock
  assign sck_o   = is_shift(st_q) && !cnt_q[0];
  assign done_o  = done_q;

  // consecutive chip-select high cycles, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_run_q <= CNT_W'(GAP_CYC);
    else if (cs_n_o) hi_run_q <= (hi_run_q >= CNT_W'(GAP_CYC)) ? hi_run_q : hi_run_q + CNT_W'(1);
    else             hi_run_q <= '0;
  end

  assert_cs_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> hi_run_q >= CNT_W'(GAP_CYC));
  assert_sck_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o);
  assert_sck_half_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |=> $fell(sck_o));
  assert_done_edge_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && $past(!cs_n_o)));
endmodule

// File: rtl/opi_tx_mux.sv
module opi_tx_mux
  import opi_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  state_e                 state_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  kind_e                  kind_i,
  input  logic [31:0]            addr_i,
  input  logic [8*MAX_BYTES-1:0] wdata_i,
  input  logic [LEN_W-1:0]       nbytes_i,
  output logic [7:0]             dq_o,
  output logic                   oe_o
);
  localparam int BIDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  always_comb begin
    dq_o = '0;
    case (state_i)
      ST_CMD: dq_o = opcode_byte(kind_i);
      ST_ADDR: begin
        case (cnt_i[1:0])
          2'd0:    dq_o = addr_i[31:24];
          2'd1:    dq_o = addr_i[23:16];
          2'd2:    dq_o = addr_i[15:8];
          default: dq_o = addr_i[7:0];
        endcase
      end
      ST_DATA:
        if (!is_read(kind_i) && (cnt_i < CNT_W'(nbytes_i)))
          dq_o = wdata_i[8*cnt_i[BIDX_W-1:0] +: 8];
      default: dq_o = '0;
    endcase
  end

  assign oe_o = (state_i == ST_CMD) || (state_i == ST_ADDR) ||
                (!is_read(kind_i) && ((state_i == ST_DUMMY) || (state_i == ST_DATA)));

  assert_cmd_pair_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CMD && cnt_i[0]) |-> (dq_o == $past(dq_o)));
endmodule

// File: rtl/opi_rx_cap.sv
module opi_rx_cap
  import opi_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4,
  parameter int CNT_W     = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  state_e                 state_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  kind_e                  kind_i,
  input  logic [LEN_W-1:0]       nbytes_i,
  input  logic [7:0]             dq_i,
  input  logic                   oe_i,
  output logic [8*MAX_BYTES-1:0] rd_data_o
);
  logic cap_en;
  assign cap_en = (state_i == ST_DATA) && is_read(kind_i) && (cnt_i < CNT_W'(nbytes_i));

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               b_q <= '0;
      else if (start_i)                          b_q <= '0;
      else if (cap_en && cnt_i == CNT_W'(g))     b_q <= dq_i;
    end
    assign rd_data_o[8*g +: 8] = b_q;
  end

  assert_turnaround_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |-> !oe_i);
endmodule

// File: rtl/opi_psram_engine.sv
module opi_psram_engine
  import opi_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int CS_SETUP  = 3,
  parameter int CS_HOLD   = 3,
  parameter int CS_HIGH   = 2,
  parameter int RD_DUMMY  = 18,
  parameter int WR_DUMMY  = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [1:0]             req_kind_i,
  input  logic [31:0]            req_addr_i,
  input  logic [8*MAX_BYTES-1:0] req_wdata_i,
  input  logic [LEN_W-1:0]       req_len_i,
  output logic                   done_o,
  output logic [8*MAX_BYTES-1:0] rd_data_o,
  output logic                   cs_n_o,
  output logic                   sck_o,
  output logic [7:0]             dq_o,
  output logic                   dq_oe_o,
  input  logic [7:0]             dq_i
);
  localparam int EDGE_W = LEN_W + 1;
  localparam int L_A = (CS_SETUP > CS_HOLD) ? 2 * CS_SETUP : 2 * CS_HOLD;
  localparam int L_B = (L_A > 2 * CS_HIGH) ? L_A : 2 * CS_HIGH;
  localparam int L_C = (L_B > RD_DUMMY) ? L_B : RD_DUMMY;
  localparam int L_D = (L_C > WR_DUMMY) ? L_C : WR_DUMMY;
  localparam int L_E = (L_D > MAX_BYTES + 1) ? L_D : MAX_BYTES + 1;
  localparam int CNT_W = $clog2(L_E + 1);

  kind_e                  kind_in, kind_q;
  logic [31:0]            addr_q;
  logic [8*MAX_BYTES-1:0] wdata_q;
  logic [LEN_W-1:0]       len_clip, len_norm, n_q;
  logic [EDGE_W-1:0]      data_edges;
  logic                   start;
  state_e                 state;
  logic [CNT_W-1:0]       cnt;

  assign kind_in = kind_e'(req_kind_i);
  assign start   = req_valid_i && req_ready_o;

  always_comb begin
    if (req_len_i == '0)                        len_clip = LEN_W'(1);
    else if (req_len_i > LEN_W'(MAX_BYTES))     len_clip = LEN_W'(MAX_BYTES);
    else                                        len_clip = req_len_i;
    case (kind_in)
      KIND_REG_WR: len_norm = LEN_W'(2);
      KIND_REG_RD: len_norm = (len_clip > LEN_W'(2)) ? LEN_W'(2) : len_clip;
      default:     len_norm = len_clip;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= KIND_ARR_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      n_q     <= LEN_W'(1);
    end else if (start) begin
      kind_q  <= kind_in;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      n_q     <= len_norm;
    end
  end

  // whole bus clocks: round odd counts up
  assign data_edges  = EDGE_W'(n_q) + EDGE_W'(n_q[0]);
  assign req_ready_o = (state == ST_IDLE);

  opi_phase_seq #(
    .CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD), .CS_HIGH(CS_HIGH),
    .RD_DUMMY(RD_DUMMY), .WR_DUMMY(WR_DUMMY), .CNT_W(CNT_W), .EDGE_W(EDGE_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .kind_i(kind_q),
    .data_edges_i(data_edges), .state_o(state), .cnt_o(cnt),
    .cs_n_o(cs_n_o), .sck_o(sck_o), .done_o(done_o)
  );

  opi_tx_mux #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state), .cnt_i(cnt), .kind_i(kind_q),
    .addr_i(addr_q), .wdata_i(wdata_q), .nbytes_i(n_q), .dq_o(dq_o), .oe_o(dq_oe_o)
  );

  opi_rx_cap #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .state_i(state), .cnt_i(cnt),
    .kind_i(kind_q), .nbytes_i(n_q), .dq_i(dq_i), .oe_i(dq_oe_o), .rd_data_o(rd_data_o)
  );

  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> req_valid_i);
  assert_ready_cs_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_ready_o) |-> cs_n_o);
endmodule

// File: tb/tb_opi_psram_engine.sv
module tb_opi_psram_engine;
  localparam int MAXB = 8;
  localparam int SETUP_CYC = 6, HOLD_CYC = 6, GAP_MIN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            req_valid = 1'b0, req_ready;
  logic [1:0]      req_kind = '0;
  logic [31:0]     req_addr = '0;
  logic [63:0]     req_wdata = '0;
  logic [3:0]      req_len = '0;
  logic            done, cs_n, sck, dq_oe;
  logic [63:0]     rd_data;
  logic [7:0]      dq_out, dq_in = '0;

  opi_psram_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_len_i(req_len), .done_o(done), .rd_data_o(rd_data), .cs_n_o(cs_n),
    .sck_o(sck), .dq_o(dq_out), .dq_oe_o(dq_oe), .dq_i(dq_in)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] mem [256];
  logic [7:0] regs [16];

  // bus monitor and device model state
  logic       prev_sck = 1'b0, prev_cs = 1'b1;
  int         hi_run = 100, m_gap = 0, m_slots = 0, m_setup = 0, m_hold = 0;
  int         m_oe_bad = 0, sck_bad = 0, s_i, dn_i, d_i;
  logic [7:0] m_cmd0 = '0, m_cmd1 = '0;
  logic [31:0] m_addr = '0;
  logic [63:0] m_wb = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int dummy_of(input logic [7:0] op);
    if (op == 8'hC0) return 0;
    if (op == 8'h80) return 8;
    return 18;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n) begin
        if (sck) sck_bad++;
        hi_run++;
      end else begin
        if (prev_cs) begin
          m_gap = hi_run; hi_run = 0; m_slots = 0; m_setup = 0; m_hold = 0;
          m_oe_bad = 0; m_addr = '0; m_cmd0 = '0; m_cmd1 = '0; m_wb = '0;
        end
        if (sck != prev_sck) begin
          s_i = m_slots; m_hold = 0;
          if (s_i == 0) m_cmd0 = dq_out;
          else if (s_i == 1) m_cmd1 = dq_out;
          else if (s_i < 6) m_addr = {m_addr[23:0], dq_out};
          dn_i = dummy_of(m_cmd0);
          if (s_i < 6) begin if (!dq_oe) m_oe_bad++; end
          else if (!m_cmd0[7]) begin if (dq_oe) m_oe_bad++; end
          else if (!dq_oe) m_oe_bad++;
          if (s_i >= 6 + dn_i) begin
            d_i = s_i - 6 - dn_i;
            if (!m_cmd0[7])
              dq_in = (m_cmd0 == 8'h40) ? regs[4'(m_addr[3:0] + 4'(d_i))]
                                        : mem[8'(m_addr[7:0] + 8'(d_i))];
            else if (d_i < 8) m_wb[8*d_i +: 8] = dq_out;
          end
          m_slots++;
        end else if (m_slots == 0) begin
          m_setup++;
        end else begin
          m_hold++;
          if (!m_cmd0[7] && dq_oe) m_oe_bad++;
        end
      end
      prev_sck = sck;
      prev_cs  = cs_n;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  task automatic issue(input int kind, input logic [31:0] a, input logic [63:0] w, input int n);
    req_kind = 2'(kind); req_addr = a; req_wdata = w; req_len = 4'(n); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R12 ready low after acceptance", 64'(req_ready), 64'd0);
  endtask

  task automatic finish_txn(input int kind, input logic [31:0] a, input logic [63:0] w, input int n);
    int l, edges, dn;
    logic [7:0] op;
    logic [63:0] ew, er;
    while (!done) @(negedge clk);
    l = (n == 0) ? 1 : (n > MAXB) ? MAXB : n;
    if (kind == 2 && l > 2) l = 2;
    if (kind == 3) l = 2;
    edges = l + (l % 2);
    dn = (kind == 3) ? 0 : (kind == 1) ? 8 : 18;
    op = (kind == 0) ? 8'h00 : (kind == 1) ? 8'h80 : (kind == 2) ? 8'h40 : 8'hC0;
    chk(m_cmd0 == op && m_cmd1 == op, "R2 opcode bytes", {m_cmd0, m_cmd1}, {op, op});
    chk(m_addr == a, "R3 address bytes", m_addr, a);
    chk(m_slots == 6 + dn + edges, "R4 total edges with dummy", m_slots, 6 + dn + edges);
    chk(m_setup == SETUP_CYC, "R5 chip-select setup", m_setup, SETUP_CYC);
    chk(m_hold == HOLD_CYC, "R5 chip-select hold", m_hold, HOLD_CYC);
    chk(m_gap >= GAP_MIN, "R6 chip-select high time", m_gap, GAP_MIN);
    chk(m_oe_bad == 0, "R8 output enable", m_oe_bad, 0);
    chk(cs_n, "R12 done as chip select rises", 64'(cs_n), 64'd1);
    if (kind == 1 || kind == 3) begin
      ew = '0;
      for (int d = 0; d < l; d++) ew[8*d +: 8] = w[8*d +: 8];
      chk(m_wb == ew, (kind == 3) ? "R11 register write bytes" : "R9 array write bytes", m_wb, ew);
      for (int d = 0; d < l; d++)
        if (kind == 3) regs[4'(a[3:0] + 4'(d))] = w[8*d +: 8];
        else           mem[8'(a[7:0] + 8'(d))] = w[8*d +: 8];
    end else begin
      er = '0;
      for (int d = 0; d < l; d++)
        er[8*d +: 8] = (kind == 2) ? regs[4'(a[3:0] + 4'(d))] : mem[8'(a[7:0] + 8'(d))];
      chk(rd_data == er, (kind == 2) ? "R11 register read bytes" : "R10 array read bytes", rd_data, er);
    end
    @(negedge clk);
    chk(!done, "R12 done single cycle", 64'(done), 64'd0);
    chk(cs_n && !sck, "R7 clock low while deselected", {cs_n, sck}, 2'b10);
    if (kind == 0 || kind == 2)
      chk(rd_data == er, "R12 read data held", rd_data, er);
  endtask

  task automatic run(input int kind, input logic [31:0] a, input logic [63:0] w, input int n);
    issue(kind, a, w, n);
    finish_txn(kind, a, w, n);
  endtask

  initial begin
    logic [31:0] a;
    int k, n;
    logic [63:0] w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 16; i++) regs[i] = 8'(8'h50 + i * 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sck && !dq_oe && req_ready && !done, "R1 reset state",
        {cs_n, sck, dq_oe, req_ready, done}, 5'b10010);

    // directed corners
    run(2, 32'h0, 64'h0, 1);                       // R11 single register byte
    run(2, 32'h2, 64'h0, 2);                       // R11 register pair
    run(2, 32'h4, 64'h0, 7);                       // R11 register read clamp
    run(3, 32'h6, 64'hFFFF_FFFF_FFFF_A55A, 1);     // R11 register write ignores count
    run(2, 32'h6, 64'h0, 2);
    run(0, 32'h1234_5610, 64'h0, 0);               // R10 count zero
    run(0, 32'hDEAD_BEF8, 64'h0, 15);              // R10 count clamp
    run(1, 32'h0000_0040, 64'h1122_3344_5566_7788, 3); // R9 odd count pad
    run(0, 32'h0000_0040, 64'h0, 4);
    run(1, 32'h8000_00F0, 64'h0102_0304_0506_0708, 8);
    run(0, 32'h8000_00F0, 64'h0, 8);

    // R12 request waiting behind a busy transaction
    issue(0, 32'h0000_0020, 64'h0, 5);
    fork
      issue(1, 32'h0000_0020, 64'hCAFE_F00D_0BAD_BEEF, 6);
      finish_txn(0, 32'h0000_0020, 64'h0, 5);
    join
    finish_txn(1, 32'h0000_0020, 64'hCAFE_F00D_0BAD_BEEF, 6);
    run(0, 32'h0000_0020, 64'h0, 6);

    for (int i = 0; i < 60; i++) begin
      k = int'($urandom % 4);
      a = (k >= 2) ? 32'(($urandom % 8) * 2) : $urandom;
      w = {$urandom, $urandom};
      n = int'($urandom % 10);
      run(k, a, w, n);
    end
    chk(sck_bad == 0, "R7 clock idle low", sck_bad, 0);
    summary();
    $finish;
  end
endmodule